// File: doc/BRIEF.md
# RTC Protected Register Front End

This block sits between a simple memory-mapped bus and a real-time-clock calendar core. It holds the time, date, prescaler and control words that the core runs from, and guards them. Nothing protected can change until software writes a two-byte unlock key to the key register. Even when unlocked, the calendar words and the prescaler only accept writes once an initialization-mode request has been acknowledged by hardware. While that acknowledgement is high, the core is told to hold its count.

A resynchronization flag in the status register tells software when the calendar shadow values can be trusted again. Software clears the flag. Hardware raises it a fixed number of cycles after the shadow copy is refreshed. A refresh is either a pulse from the core or the exit from initialization mode. Reads are combinational and always allowed. The bus has no wait states.

Top module: `rtc_guard_regs`

## Requirements
- R1: After reset, time, date and control read 0, the prescaler reads 0x007F00FF, status reads 0 and `calHold` is low.
- R2: Unless the key state is open, bus writes to the INIT bit (status bit 7), control, prescaler, time and date leave those registers unchanged. Reads work regardless of the key state.
- R3: The key register is at offset 0x24. The key state opens only when a key write of 0xCA is followed, with no other key write between them, by a key write of 0x53. Any other key write, including 0xFF, leaves the key state closed.
- R4: Status bit 6 (INITF) and `calHold` read 1 starting two clock edges after the edge that accepts INIT=1. They drop on the edge that accepts INIT=0.
- R5: Time (0x00), date (0x04) and prescaler (0x10) writes take effect only while INITF is 1.
- R6: Status bit 4 (INITS) reads 1 exactly when the year field (date bits 23:16) is nonzero.
- R7: The key register and unmapped offsets always read 0.
- R8: Stored values keep only their defined fields: time & 0x003F7F7F, date & 0x00FFFF3F, prescaler & 0x007F7FFF, control (0x18) & 0x000000FF.
- R9: A status write (0x0C) with bit 5 at 0 clears RSF whatever the key state. Writing bit 5 as 1 has no effect on RSF.
- R10: RSF (status bit 5) reads 1 starting two edges after a refresh event. A refresh event is an accepted INIT 1→0 or a `shadowTick` pulse sampled while INITF is 0; a pulse while INITF is 1 is ignored. A hardware set wins over a same-cycle clear.
- R11: `calTime`, `calDate`, `calPresc` and `calCtrl` always equal the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte offset of the register |
| wrData | input | 32 | Write data |
| wrEn | input | 1 | Write strobe, accepted on the clock edge |
| rdEn | input | 1 | Read enable; `rdData` is 0 when low |
| rdData | output | 32 | Combinational read data |
| shadowTick | input | 1 | Pulse from the core when it refreshes its shadow copy |
| calTime | output | 32 | Stored time word |
| calDate | output | 32 | Stored date word |
| calPresc | output | 32 | Stored prescaler word |
| calCtrl | output | 8 | Stored control byte |
| calHold | output | 1 | Initialization acknowledged; the core must freeze |

## Verification
Most state errors show up at the ports within a few cycles. A key machine stuck open, or one that opens on the wrong sequence, shows up on the next protected write, which changes a readback that should not change. An off-by-one in the acknowledgement counter moves the INITF readback a cycle early or late, so the bench reads status in each cycle right after the INIT write. The same applies to RSF after an exit or a tick. A wrong event filter makes RSF appear when the core is frozen, which a readback shows three cycles later.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;
  localparam int AddrW = 8;
  localparam int DataW = 32;

  localparam logic [AddrW-1:0] ADDR_TIME  = 8'h00;
  localparam logic [AddrW-1:0] ADDR_DATE  = 8'h04;
  localparam logic [AddrW-1:0] ADDR_STAT  = 8'h0C;
  localparam logic [AddrW-1:0] ADDR_PRESC = 8'h10;
  localparam logic [AddrW-1:0] ADDR_CTRL  = 8'h18;
  localparam logic [AddrW-1:0] ADDR_KEY   = 8'h24;

  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

  localparam logic [DataW-1:0] MASK_TIME  = 32'h003F_7F7F;
  localparam logic [DataW-1:0] MASK_DATE  = 32'h00FF_FF3F;
  localparam logic [DataW-1:0] MASK_PRESC = 32'h007F_7FFF;
  localparam logic [DataW-1:0] RST_PRESC  = 32'h007F_00FF;
  localparam int CtrlW = 8;

  localparam int STAT_INIT  = 7;
  localparam int STAT_INITF = 6;
  localparam int STAT_RSF   = 5;
  localparam int STAT_INITS = 4;

  typedef enum logic [1:0] {KEY_IDLE, KEY_HALF, KEY_OPEN} keyState_t;

  typedef struct packed {
    logic wrTime;
    logic wrDate;
    logic wrPresc;
    logic wrCtrl;
    logic initReq;
    logic initF;
    logic rsf;
  } strobes_t;
endpackage

// File: rtl/rtc_guard_ctrl.sv
module rtc_guard_ctrl
  import rtc_guard_pkg::*;
#(
  parameter int InitLat = 2,
  parameter int SyncLat = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] addr,
  input  logic [7:0]       wrByte,
  input  logic             wrEn,
  input  logic             shadowTick,
  output logic             keyOpen,
  output strobes_t         strb
);
  localparam int InitCntW = $clog2(InitLat + 1);
  localparam int SyncCntW = $clog2(SyncLat + 1);
  localparam logic [InitCntW-1:0] InitLast = InitCntW'(InitLat - 1);
  localparam logic [SyncCntW-1:0] SyncLast = SyncCntW'(SyncLat - 1);

  keyState_t keyState, keyNext;
  logic keyWr, statWr;
  logic initReq, initReqNext, initF;
  logic [InitCntW-1:0] initCnt;
  logic syncBusy, rsf, rsfSet, refreshEv;
  logic [SyncCntW-1:0] syncCnt;

  assign keyWr  = wrEn && (addr == ADDR_KEY);
  assign statWr = wrEn && (addr == ADDR_STAT);

  // key sequence: only an adjacent first/second key pair opens
  always_comb begin
    keyNext = keyState;
    if (keyWr) begin
      if (wrByte == KEY_FIRST)                               keyNext = KEY_HALF;
      else if (wrByte == KEY_SECOND && keyState == KEY_HALF) keyNext = KEY_OPEN;
      else                                                   keyNext = KEY_IDLE;
    end
  end

  assign keyOpen     = (keyState == KEY_OPEN);
  assign initReqNext = (statWr && keyOpen) ? wrByte[STAT_INIT] : initReq;
  assign refreshEv   = (initReq && !initReqNext) || (shadowTick && !initF);
  assign rsfSet      = syncBusy && (syncCnt == SyncLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyState <= KEY_IDLE;
      initReq  <= 1'b0;
      initF    <= 1'b0;
      initCnt  <= '0;
    end else begin
      keyState <= keyNext;
      initReq  <= initReqNext;
      if (!(initReq && initReqNext)) begin
        initCnt <= '0;
        initF   <= 1'b0;
      end else if (initCnt == InitLast) begin
        initF <= 1'b1;
      end else begin
        initCnt <= initCnt + 1'b1;
      end
    end
  end

  // resync timer: events arriving while a count runs are merged into it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncBusy <= 1'b0;
      syncCnt  <= '0;
      rsf      <= 1'b0;
    end else begin
      if (syncBusy) begin
        if (rsfSet) syncBusy <= 1'b0;
        else        syncCnt  <= syncCnt + 1'b1;
      end else if (refreshEv) begin
        syncBusy <= 1'b1;
        syncCnt  <= '0;
      end
      if (rsfSet)                           rsf <= 1'b1;
      else if (statWr && !wrByte[STAT_RSF]) rsf <= 1'b0;
    end
  end

  always_comb begin
    strb         = '0;
    strb.wrTime  = wrEn && keyOpen && initF && (addr == ADDR_TIME);
    strb.wrDate  = wrEn && keyOpen && initF && (addr == ADDR_DATE);
    strb.wrPresc = wrEn && keyOpen && initF && (addr == ADDR_PRESC);
    strb.wrCtrl  = wrEn && keyOpen && (addr == ADDR_CTRL);
    strb.initReq = initReq;
    strb.initF   = initF;
    strb.rsf     = rsf;
  end
endmodule

// File: rtl/rtc_guard_dpath.sv
module rtc_guard_dpath
  import rtc_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] addr,
  input  logic [DataW-1:0] wrData,
  input  logic             rdEn,
  input  strobes_t         strb,
  output logic [DataW-1:0] rdData,
  output logic [DataW-1:0] calTime,
  output logic [DataW-1:0] calDate,
  output logic [DataW-1:0] calPresc,
  output logic [CtrlW-1:0] calCtrl
);
  logic inits;
  logic [DataW-1:0] statWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calTime  <= '0;
      calDate  <= '0;
      calPresc <= RST_PRESC;
      calCtrl  <= '0;
    end else begin
      if (strb.wrTime)  calTime  <= wrData & MASK_TIME;
      if (strb.wrDate)  calDate  <= wrData & MASK_DATE;
      if (strb.wrPresc) calPresc <= wrData & MASK_PRESC;
      if (strb.wrCtrl)  calCtrl  <= wrData[CtrlW-1:0];
    end
  end

  assign inits = |calDate[23:16];

  always_comb begin
    statWord             = '0;
    statWord[STAT_INIT]  = strb.initReq;
    statWord[STAT_INITF] = strb.initF;
    statWord[STAT_RSF]   = strb.rsf;
    statWord[STAT_INITS] = inits;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (addr)
        ADDR_TIME:  rdData = calTime;
        ADDR_DATE:  rdData = calDate;
        ADDR_STAT:  rdData = statWord;
        ADDR_PRESC: rdData = calPresc;
        ADDR_CTRL:  rdData = {{(DataW-CtrlW){1'b0}}, calCtrl};
        default:    rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_guard_regs.sv
module rtc_guard_regs
  import rtc_guard_pkg::*;
#(
  parameter int InitLat = 2,
  parameter int SyncLat = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  addr,
  input  logic [31:0] wrData,
  input  logic        wrEn,
  input  logic        rdEn,
  output logic [31:0] rdData,
  input  logic        shadowTick,
  output logic [31:0] calTime,
  output logic [31:0] calDate,
  output logic [31:0] calPresc,
  output logic [7:0]  calCtrl,
  output logic        calHold
);
  strobes_t strb;
  logic keyOpen;

  rtc_guard_ctrl #(.InitLat(InitLat), .SyncLat(SyncLat)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrByte(wrData[7:0]),
    .wrEn(wrEn), .shadowTick(shadowTick), .keyOpen(keyOpen), .strb(strb)
  );

  rtc_guard_dpath u_dpath (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .rdEn(rdEn),
    .strb(strb), .rdData(rdData), .calTime(calTime), .calDate(calDate),
    .calPresc(calPresc), .calCtrl(calCtrl)
  );

  assign calHold = strb.initF;
endmodule

// File: rtl/rtc_guard_regs_chk.sv
module rtc_guard_regs_chk
  import rtc_guard_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  addr,
  input logic        wrEn,
  input logic        rdEn,
  input logic [31:0] rdData,
  input logic [31:0] calTime,
  input logic        calHold,
  input logic        keyOpen,
  input logic        initReq,
  input logic        rsf
);
  AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_KEY) |-> (rdData == '0)); // R7
  AST_LOCKED_TIME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_TIME && !keyOpen) |=> $stable(calTime)); // R2
  AST_NOINIT_TIME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_TIME && !calHold) |=> $stable(calTime)); // R5
  AST_HOLD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    calHold |-> initReq); // R4
  AST_HOLD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calHold) |-> $past(initReq, 2)); // R4
  AST_RSF_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(initReq) |-> ##2 rsf); // R10
endmodule

bind rtc_guard_regs rtc_guard_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .rdData(rdData), .calTime(calTime), .calHold(calHold), .keyOpen(keyOpen),
  .initReq(strb.initReq), .rsf(strb.rsf)
);

// File: tb/rtc_guard_regs_bench.sv
module rtc_guard_regs_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic        shadowTick = 1'b0;
  logic [31:0] rdData, calTime, calDate, calPresc;
  logic [7:0]  calCtrl;
  logic        calHold;

  int checks = 0;
  int failures = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  rtc_guard_regs u_rtc_guard_regs (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .shadowTick(shadowTick), .calTime(calTime),
    .calDate(calDate), .calPresc(calPresc), .calCtrl(calCtrl), .calHold(calHold)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every read cycle pops one expected item
  always @(negedge clk) begin
    if (rdEn && rstN) begin
      if (expQ.size() == 0) check("SCOREBOARD_UNDERRUN", rdData, 32'hX);
      else check(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  task automatic drive(logic w, logic r, logic t, logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    wrEn = w; rdEn = r; shadowTick = t; addr = a; wrData = d;
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    drive(1'b1, 1'b0, 1'b0, a, d);
  endtask

  task automatic busRead(logic [7:0] a, logic [31:0] exp, string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    drive(1'b0, 1'b1, 1'b0, a, '0);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic pulseTick();
    drive(1'b0, 1'b0, 1'b1, '0, '0);
  endtask

  task automatic unlock();
    busWrite(8'h24, 32'hCA);
    busWrite(8'h24, 32'h53);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset values
    busRead(8'h00, 32'h0, "R1 time");
    busRead(8'h04, 32'h0, "R1 date");
    busRead(8'h10, 32'h007F00FF, "R1 presc");
    busRead(8'h18, 32'h0, "R1 ctrl");
    busRead(8'h0C, 32'h0, "R1 status");
    idle();
    @(negedge clk) check("R1 calHold", {31'b0, calHold}, 32'h0);
    // R2 locked writes ignored
    busWrite(8'h18, 32'h40);
    busRead(8'h18, 32'h0, "R2 ctrl locked");
    busWrite(8'h0C, 32'h80);
    busRead(8'h0C, 32'h0, "R2 init locked");
    // R3 broken sequences
    busWrite(8'h24, 32'hCA);
    busWrite(8'h24, 32'h11);
    busWrite(8'h24, 32'h53);
    busWrite(8'h18, 32'h44);
    busRead(8'h18, 32'h0, "R3 interrupted key");
    busWrite(8'h24, 32'h53);
    busWrite(8'h18, 32'h44);
    busRead(8'h18, 32'h0, "R3 second key alone");
    unlock();
    busWrite(8'h18, 32'h1FF);
    busRead(8'h18, 32'hFF, "R3 R8 ctrl unlocked masked");
    busRead(8'h24, 32'h0, "R7 key reads zero");
    busRead(8'h08, 32'h0, "R7 unmapped");
    // R5 no init mode
    busWrite(8'h00, 32'h00123456);
    busRead(8'h00, 32'h0, "R5 time without init");
    // R4 handshake timing
    busWrite(8'h0C, 32'h80);
    busRead(8'h0C, 32'h80, "R4 cycle0");
    busRead(8'h0C, 32'h80, "R4 cycle1");
    busRead(8'h0C, 32'hC0, "R4 cycle2");
    // R5 R8 writes in init
    busWrite(8'h00, 32'hFF123456);
    busRead(8'h00, 32'h00123456, "R5 R8 time");
    busWrite(8'h04, 32'hFF19FFFF);
    busRead(8'h04, 32'h0019FF3F, "R5 R8 date");
    busWrite(8'h10, 32'hFFFFFFFF);
    busRead(8'h10, 32'h007F7FFF, "R5 R8 presc");
    @(negedge clk) check("R11 calTime", calTime, 32'h00123456);
    check("R11 calDate", calDate, 32'h0019FF3F);
    check("R4 calHold", {31'b0, calHold}, 32'h1);
    busRead(8'h0C, 32'hD0, "R6 inits set");
    // R2 relock during init
    busWrite(8'h24, 32'hFF);
    busWrite(8'h00, 32'h0);
    busRead(8'h00, 32'h00123456, "R2 time relocked");
    busWrite(8'h0C, 32'h00);
    busRead(8'h0C, 32'hD0, "R2 init clear locked");
    // R10 exit timing
    unlock();
    busWrite(8'h0C, 32'h00);
    busRead(8'h0C, 32'h10, "R10 exit cycle0");
    busRead(8'h0C, 32'h10, "R10 exit cycle1");
    busRead(8'h0C, 32'h30, "R10 exit cycle2");
    // R9 clear behaviour
    busWrite(8'h0C, 32'h20);
    busRead(8'h0C, 32'h30, "R9 write one keeps");
    busWrite(8'h0C, 32'h00);
    busRead(8'h0C, 32'h10, "R9 clear");
    // R10 tick
    pulseTick();
    busRead(8'h0C, 32'h10, "R10 tick cycle0");
    busRead(8'h0C, 32'h10, "R10 tick cycle1");
    busRead(8'h0C, 32'h30, "R10 tick cycle2");
    busWrite(8'h24, 32'hFF);
    busWrite(8'h0C, 32'h00);
    busRead(8'h0C, 32'h10, "R9 clear while locked");
    // R10 tick ignored in init, R6 year zero
    unlock();
    busWrite(8'h0C, 32'h80);
    idle();
    idle();
    busRead(8'h0C, 32'hD0, "R4 init again");
    pulseTick();
    busRead(8'h0C, 32'hD0, "R10 tick ignored c0");
    busRead(8'h0C, 32'hD0, "R10 tick ignored c1");
    busRead(8'h0C, 32'hD0, "R10 tick ignored c2");
    busWrite(8'h04, 32'h00000101);
    busRead(8'h0C, 32'hC0, "R6 year zero");
    busWrite(8'h0C, 32'h00);
    idle();
    idle();
    busRead(8'h0C, 32'h20, "R10 R6 after exit");
    busRead(8'h04, 32'h00000101, "R5 date kept");
    idle();
    @(negedge clk) check("R11 calPresc", calPresc, 32'h007F7FFF);
    check("R11 calCtrl", {24'b0, calCtrl}, 32'hFF);
    check("R4 calHold released", {31'b0, calHold}, 32'h0);
    check("SCOREBOARD_DRAINED", expQ.size(), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule